// File: doc/BRIEF.md
# Byte-Wide Asynchronous SRAM Controller

This block sits between a 16-bit processor and a single asynchronous SRAM that is only eight bits wide. It runs from a clock at twice the processor rate, so each of its clock periods is one half of a processor cycle. The output `cyc_half` tells the processor which half is current. Requests are sampled at the processor cycle boundary, which is the edge that ends a half with `cyc_half` high.

A read fetches a whole 16-bit word in one processor cycle. The upper address is registered at the boundary and the low address bit follows the half-cycle phase, so one byte is captured at the end of each half. Stores run a glitch-free sequence built from half-cycle steps. The address settles first, `/WE` is then driven low for exactly one half, and `/WE` is then released while address and data stay unchanged. A word store repeats this sequence for each byte. While a store is running, the controller raises `stall` and holds the store address and data internally.

Every control pin comes straight from a flip-flop and every transition is tied to a clock edge, so the timing holds with a slow or stopped clock.

Top module: `bytewide_sram_ctrl`

## Requirements
- R1: In reset, `sram_we_n` and `sram_oe_n` are 1, `sram_dout_en`, `stall` and `rvalid` are 0, and `sram_ce_n` is 0 at all times.
- R2: `cyc_half` toggles on every clock. Outside a store, `sram_a0` equals `cyc_half`.
- R3: A read (`req`=1, `wr`=0) sampled at a boundary is followed by a cycle with `sram_oe_n`=0 and `sram_addr`=`addr[AW-1:1]`. `rdata` is `{byte at a0=0, byte at a0=1}`, and `rvalid` is 1 during the whole following processor cycle.
- R4: `sram_we_n` is never low for two clocks in a row. Address, low bit and data are unchanged at the clock where it falls and at the clock where it rises, and `sram_dout_en` is 1 while it rises.
- R5: A byte store (`word`=0) lasts four halves. `sram_a0`=`addr[0]` throughout, with a single `/WE` low pulse in half 2 carrying `wdata[7:0]`.
- R6: A word store (`word`=1) lasts six halves. `/WE` is low in half 2 (a0=0, data `wdata[15:8]`) and in half 5 (a0=1, data `wdata[7:0]`), and `sram_a0` changes only in half 4. `addr[0]` is ignored.
- R7: `sram_oe_n` is 1 in every half of a store and returns to 0 in the first half after it.
- R8: `sram_dout_en` is 0 in the first half of a store. It is 1 in halves 2 and 3 of a byte store and 0 in its half 4. It is 1 in halves 2 to 6 of a word store. It is 0 outside stores.
- R9: `stall` is 1 from the first half of a store through the half before its last, and 0 in the last half. A new request is accepted at the boundary that ends the store.
- R10: `sram_oe_n` and `sram_we_n` are never low together, and `sram_dout_en`=1 implies `sram_oe_n`=1.
- R11: With `req`=0 no `/WE` pulse occurs and `rvalid` stays 0. `addr[0]` has no effect on reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the processor rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | Access request, sampled at the cycle boundary |
| wr | input | 1 | 1 = store, 0 = read |
| word | input | 1 | Store size: 1 = 16-bit, 0 = byte |
| addr | input | AW | Byte address |
| wdata | input | 2*BW | Store data; byte stores use the low byte |
| stall | output | 1 | Store in progress; processor holds its next request |
| rdata | output | 2*BW | Read word, high byte from even address |
| rvalid | output | 1 | `rdata` valid for this processor cycle |
| cyc_half | output | 1 | 0 = first half, 1 = second half of processor cycle |
| sram_addr | output | AW-1 | SRAM upper address bits |
| sram_a0 | output | 1 | SRAM lowest address bit |
| sram_ce_n | output | 1 | SRAM chip enable, tied active |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_dout | output | BW | Data toward the SRAM |
| sram_dout_en | output | 1 | Enable for the data-out drivers |
| sram_din | input | BW | Data from the SRAM |

## Verification
The bench follows every store half by half. A sequencer that moved the low address bit in the same half as a `/WE` edge would write the wrong byte, and this shows up as a corrupted read-back. A sequencer that released the data-out enable early in a word store would show a mismatch in the enable pattern of half 6. A bench memory model commits bytes only on the rising edge of `/WE`, so a missing return to high, or a pulse on the wrong byte lane, appears as a read-back mismatch. Odd addresses on word stores and reads confirm that the low address bit is ignored there. Idle cycles confirm that the low address bit follows the phase.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   typedef enum logic [1:0] {
      WR_IDLE = 2'd0,
      WR_BYTE = 2'd1,
      WR_WORD = 2'd2
   } wr_mode_t;

   localparam logic [2:0] BYTE_LAST = 3'd3;
   localparam logic [2:0] WORD_LAST = 3'd5;

   typedef struct packed {
      logic we_n;
      logic oe_n;
      logic den;
      logic a0;
      logic sel_lo;
   } pin_set_t;

   // Pin levels for a given store step; idle_a0 is the phase value outside stores
   function automatic pin_set_t step_decode(input wr_mode_t mode, input logic [2:0] step,
                                            input logic lo_bit, input logic idle_a0);
      pin_set_t p;
      p = '{we_n: 1'b1, oe_n: 1'b0, den: 1'b0, a0: idle_a0, sel_lo: 1'b0};
      case (mode)
         WR_BYTE: begin
            p.oe_n   = 1'b1;
            p.we_n   = (step != 3'd1);
            p.den    = (step == 3'd1) || (step == 3'd2);
            p.a0     = lo_bit;
            p.sel_lo = 1'b1;
         end
         WR_WORD: begin
            p.oe_n   = 1'b1;
            p.we_n   = !((step == 3'd1) || (step == 3'd4));
            p.den    = (step != 3'd0);
            p.a0     = (step >= 3'd3);
            p.sel_lo = (step >= 3'd3);
         end
         default: ;
      endcase
      return p;
   endfunction

endpackage

// File: rtl/bsram_phase.sv
module bsram_phase (
   input  logic clk,
   input  logic rst_n,
   output logic half
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) half <= 1'b0;
      else        half <= ~half;
   end
endmodule

// File: rtl/bsram_rd_cap.sv
module bsram_rd_cap #(
   parameter int BW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            half,
   input  logic [BW-1:0]   din,
   output logic [2*BW-1:0] rdata,
   output logic            rvalid
);
   logic          act_q;
   logic [BW-1:0] hi_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         hi_q   <= '0;
         rdata  <= '0;
         rvalid <= 1'b0;
      end else if (!half) begin
         if (act_q) hi_q <= din;
      end else begin
         rvalid <= act_q;
         if (act_q) rdata <= {hi_q, din};
         act_q <= start;
      end
   end
endmodule

// File: rtl/bsram_wr_seq.sv
module bsram_wr_seq
   import bsram_pkg::*;
#(
   parameter int BW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            is_word,
   input  logic            lo_bit,
   input  logic            half,
   input  logic [2*BW-1:0] wdata,
   output logic            active,
   output logic            last,
   output logic            we_n,
   output logic            oe_n,
   output logic            den,
   output logic            a0,
   output logic [BW-1:0]   dout
);
   wr_mode_t        mode_q, mode_d;
   logic [2:0]      step_q, step_d;
   logic            lo_q, lo_src;
   logic [2*BW-1:0] wd_q, wd_src;
   pin_set_t        nx;

   assign active = (mode_q != WR_IDLE);
   assign last   = ((mode_q == WR_BYTE) && (step_q == BYTE_LAST)) ||
                   ((mode_q == WR_WORD) && (step_q == WORD_LAST));

   always_comb begin
      mode_d = mode_q;
      step_d = step_q;
      if (start) begin
         mode_d = is_word ? WR_WORD : WR_BYTE;
         step_d = 3'd0;
      end else if (last) begin
         mode_d = WR_IDLE;
         step_d = 3'd0;
      end else if (active) begin
         step_d = step_q + 3'd1;
      end
      lo_src = start ? lo_bit : lo_q;
      wd_src = start ? wdata  : wd_q;
      nx     = step_decode(mode_d, step_d, lo_src, ~half);
   end

   // Pins are registered from the next state so each one leaves a flip-flop
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= WR_IDLE;
         step_q <= 3'd0;
         lo_q   <= 1'b0;
         wd_q   <= '0;
         we_n   <= 1'b1;
         oe_n   <= 1'b1;
         den    <= 1'b0;
         a0     <= 1'b0;
         dout   <= '0;
      end else begin
         mode_q <= mode_d;
         step_q <= step_d;
         lo_q   <= lo_src;
         wd_q   <= wd_src;
         we_n   <= nx.we_n;
         oe_n   <= nx.oe_n;
         den    <= nx.den;
         a0     <= nx.a0;
         dout   <= nx.sel_lo ? wd_src[BW-1:0] : wd_src[2*BW-1:BW];
      end
   end

   assert_we_one_half_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |=> we_n);
   assert_stall_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !last) |=> active);
endmodule

// File: rtl/bytewide_sram_ctrl.sv
module bytewide_sram_ctrl #(
   parameter int AW = 10,
   parameter int BW = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req,
   input  logic            wr,
   input  logic            word,
   input  logic [AW-1:0]   addr,
   input  logic [2*BW-1:0] wdata,
   output logic            stall,
   output logic [2*BW-1:0] rdata,
   output logic            rvalid,
   output logic            cyc_half,
   output logic [AW-2:0]   sram_addr,
   output logic            sram_a0,
   output logic            sram_ce_n,
   output logic            sram_oe_n,
   output logic            sram_we_n,
   output logic [BW-1:0]   sram_dout,
   output logic            sram_dout_en,
   input  logic [BW-1:0]   sram_din
);
   localparam int UAW = AW - 1;

   generate
      if (AW < 2) begin : g_bad_aw
         $error("bytewide_sram_ctrl: AW must be at least 2");
      end
      if (BW < 1) begin : g_bad_bw
         $error("bytewide_sram_ctrl: BW must be at least 1");
      end
   endgenerate

   logic           half, wr_active, wr_last, boundary_ok, wr_go, rd_go;
   logic [UAW-1:0] addr_q;

   bsram_phase u_phase (.clk(clk), .rst_n(rst_n), .half(half));

   assign boundary_ok = half && (!wr_active || wr_last);
   assign wr_go       = req && wr  && boundary_ok;
   assign rd_go       = req && !wr && boundary_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              addr_q <= '0;
      else if (wr_go || rd_go) addr_q <= addr[AW-1:1];
   end

   bsram_wr_seq #(.BW(BW)) u_wr (
      .clk(clk), .rst_n(rst_n), .start(wr_go), .is_word(word), .lo_bit(addr[0]),
      .half(half), .wdata(wdata), .active(wr_active), .last(wr_last),
      .we_n(sram_we_n), .oe_n(sram_oe_n), .den(sram_dout_en), .a0(sram_a0),
      .dout(sram_dout)
   );

   bsram_rd_cap #(.BW(BW)) u_rd (
      .clk(clk), .rst_n(rst_n), .start(rd_go), .half(half), .din(sram_din),
      .rdata(rdata), .rvalid(rvalid)
   );

   assign stall     = wr_active && !wr_last;
   assign cyc_half  = half;
   assign sram_addr = addr_q;
   assign sram_ce_n = 1'b0;

   assert_we_fall_addr_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_a0)));
   assert_we_rise_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> ($stable(sram_addr) && $stable(sram_a0) &&
                            $stable(sram_dout) && sram_dout_en));
   assert_no_oe_we_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(!sram_oe_n && !sram_we_n));
   assert_den_oe_R10: assert property (@(posedge clk) disable iff (!rst_n)
      sram_dout_en |-> sram_oe_n);
   assert_phase_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_half |=> !cyc_half);
   assert_rvalid_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rvalid) |=> rvalid);
endmodule

// File: tb/bytewide_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module bytewide_sram_ctrl_tb_top;
   localparam int AW = 10;
   localparam int BW = 8;
   localparam int NV = 9;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req = 1'b0, wr = 1'b0, word = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [15:0] wdata = '0;
   logic stall, rvalid, cyc_half, sram_a0, sram_ce_n, sram_oe_n, sram_we_n, sram_dout_en;
   logic [15:0] rdata;
   logic [AW-2:0] sram_addr;
   logic [7:0] sram_dout, sram_din;

   logic [7:0] mem [0:(1<<AW)-1];
   logic [7:0] exp_mem [0:(1<<AW)-1];
   logic armed = 1'b0;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   bytewide_sram_ctrl #(.AW(AW), .BW(BW)) dut_i (
      .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .word(word), .addr(addr),
      .wdata(wdata), .stall(stall), .rdata(rdata), .rvalid(rvalid), .cyc_half(cyc_half),
      .sram_addr(sram_addr), .sram_a0(sram_a0), .sram_ce_n(sram_ce_n),
      .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n), .sram_dout(sram_dout),
      .sram_dout_en(sram_dout_en), .sram_din(sram_din)
   );

   // SRAM model: commits a byte on the rising edge of /WE
   assign sram_din = mem[{sram_addr, sram_a0}];
   always @(posedge sram_we_n) if (armed && !sram_ce_n) mem[{sram_addr, sram_a0}] <= sram_dout;

   // {is_store, is_word, addr, data}
   localparam logic [27:0] VEC [NV] = '{
      {1'b1, 1'b1, 10'h010, 16'hA55A},
      {1'b1, 1'b0, 10'h021, 16'h0037},
      {1'b1, 1'b0, 10'h020, 16'h00C4},
      {1'b1, 1'b1, 10'h031, 16'h1234},
      {1'b0, 1'b0, 10'h010, 16'h0000},
      {1'b0, 1'b0, 10'h021, 16'h0000},
      {1'b0, 1'b0, 10'h030, 16'h0000},
      {1'b0, 1'b0, 10'h0FF, 16'h0000},
      {1'b0, 1'b0, 10'h011, 16'h0000}
   };

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s at %0t: actual %0h expected %0h", rq, $time, act, exp);
      end
   endtask

   task automatic go_boundary();
      do @(negedge clk); while (cyc_half !== 1'b1);
   endtask

   task automatic do_store(input logic is_word, input logic [AW-1:0] a, input logic [15:0] d);
      logic [5:0] we_p, den_p, a0_p, st_p;
      int n;
      n    = is_word ? 6 : 4;
      we_p = is_word ? 6'b101101 : 6'b001101;
      den_p= is_word ? 6'b111110 : 6'b000110;
      a0_p = is_word ? 6'b111000 : {6{a[0]}};
      st_p = is_word ? 6'b011111 : 6'b000111;
      go_boundary();
      req = 1'b1; wr = 1'b1; word = is_word; addr = a; wdata = d;
      @(posedge clk); #1 req = 1'b0;
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         chk(sram_we_n === we_p[k], is_word ? "R6 we_n" : "R5 we_n", sram_we_n, we_p[k]);
         chk(sram_a0 === a0_p[k], is_word ? "R6 a0" : "R5 a0", sram_a0, a0_p[k]);
         chk(sram_dout_en === den_p[k], "R8 dout_en", sram_dout_en, den_p[k]);
         chk(stall === st_p[k], "R9 stall", stall, st_p[k]);
         chk(sram_oe_n === 1'b1, "R7 oe_n in store", sram_oe_n, 1);
         chk(sram_addr === a[AW-1:1], "R4 addr held", sram_addr, a[AW-1:1]);
         if (k == 1)
            chk(sram_dout === (is_word ? d[15:8] : d[7:0]), "R4 data first pulse", sram_dout,
                is_word ? d[15:8] : d[7:0]);
         if (k == 4)
            chk(sram_dout === d[7:0], "R6 data second pulse", sram_dout, d[7:0]);
      end
      @(negedge clk);
      chk(sram_oe_n === 1'b0, "R7 oe_n back low", sram_oe_n, 0);
      chk(sram_dout_en === 1'b0, "R8 dout_en off after", sram_dout_en, 0);
      if (is_word) begin
         exp_mem[{a[AW-1:1], 1'b0}] = d[15:8];
         exp_mem[{a[AW-1:1], 1'b1}] = d[7:0];
      end else begin
         exp_mem[a] = d[7:0];
      end
   endtask

   task automatic do_read(input logic [AW-1:0] a);
      logic [15:0] e;
      e = {exp_mem[{a[AW-1:1], 1'b0}], exp_mem[{a[AW-1:1], 1'b1}]};
      go_boundary();
      req = 1'b1; wr = 1'b0; addr = a;
      @(posedge clk); #1 req = 1'b0;
      @(negedge clk);
      chk(sram_oe_n === 1'b0 && sram_a0 === 1'b0, "R3 first half", {sram_oe_n, sram_a0}, 0);
      chk(sram_addr === a[AW-1:1], "R3 addr", sram_addr, a[AW-1:1]);
      @(negedge clk);
      chk(sram_a0 === 1'b1, "R2 a0 second half", sram_a0, 1);
      @(negedge clk);
      chk(rvalid === 1'b1, "R3 rvalid", rvalid, 1);
      chk(rdata === e, "R3 R11 rdata", rdata, e);
      @(negedge clk);
      chk(rvalid === 1'b1, "R3 rvalid whole cycle", rvalid, 1);
      @(negedge clk);
      chk(rvalid === 1'b0, "R11 rvalid drops", rvalid, 0);
   endtask

   initial begin
      for (int i = 0; i < (1<<AW); i++) begin
         mem[i]     = 8'((i * 37 + 11) & 255);
         exp_mem[i] = 8'((i * 37 + 11) & 255);
      end
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(sram_we_n === 1'b1 && sram_oe_n === 1'b1, "R1 reset we/oe", {sram_we_n, sram_oe_n}, 3);
      chk(sram_dout_en === 1'b0 && stall === 1'b0 && rvalid === 1'b0, "R1 reset den/stall/rvalid",
          {sram_dout_en, stall, rvalid}, 0);
      chk(sram_ce_n === 1'b0, "R1 ce_n", sram_ce_n, 0);
      @(posedge clk); #1 rst_n = 1'b1; armed = 1'b1;

      // Idle: phase toggles, a0 follows it, no pulses, no read data
      begin
         logic prev;
         @(negedge clk); prev = cyc_half;
         for (int t = 0; t < 6; t++) begin
            @(negedge clk);
            chk(cyc_half !== prev, "R2 toggle", cyc_half, !prev);
            chk(sram_a0 === cyc_half, "R2 a0 tracks phase", sram_a0, cyc_half);
            chk(sram_we_n === 1'b1 && rvalid === 1'b0, "R11 idle quiet", {sram_we_n, rvalid}, 2);
            chk(!(sram_oe_n === 1'b0 && sram_we_n === 1'b0), "R10 no overlap", {sram_oe_n, sram_we_n}, 2);
            prev = cyc_half;
         end
      end

      for (int i = 0; i < NV; i++) begin
         if (VEC[i][27]) do_store(VEC[i][26], VEC[i][25:16], VEC[i][15:0]);
         else            do_read(VEC[i][25:16]);
      end

      // Byte store to an even lane must leave the odd lane untouched (R5)
      do_store(1'b0, 10'h100, 16'hFF5E);
      do_read(10'h100);
      // Word store then back-to-back reads
      do_store(1'b1, 10'h3FE, 16'hBEEF);
      do_read(10'h3FF);
      do_read(10'h000);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule